// File: doc/BRIEF.md
# SPI Master with Run-Time Clock Mode

This block is the controller side of a four-wire synchronous serial link. A host starts a transaction by pulsing a start strobe. With the strobe it supplies the first outgoing word, the clock polarity and phase, a word length, a clock divider, a chip-select wait and the index of the peripheral to address. The controller then does the following, in order:
- It parks the serial clock at its idle level.
- It pulls one active-low select line low.
- It waits the requested number of cycles.
- It exchanges words bit by bit, most significant bit first. Each received word is returned on a parallel bus with a one-cycle valid pulse.

While a transaction runs, the host may hand over one further word through a single-entry push slot. If that slot holds a word when the current word ends, the word is reloaded at once and the select line stays low. Otherwise the clock rests at its idle level and the select line is released half a clock period later. Start strobes that arrive during a transaction have no effect.

Top module: `spi_mode_master`

## Requirements
- R1: After reset every select line is high, the serial clock is 0, `busy` is 0, `rx_valid` is 0 and the data output is 0.
- R2: A start accepted while idle drives exactly select line `cs_sel` low and all others high, and that pattern holds unchanged until the transaction ends. At most one select line is ever low.
- R3: The serial clock is at the idle level given by `cpol` (0 = idle low, 1 = idle high) during the cycle before the select line falls and when it rises again. The mode number is {`cpol`,`cpha`}, so modes 0 to 3 are 00, 01, 10 and 11.
- R4: Between consecutive serial-clock transitions there are exactly `clk_div`+1 system clock cycles.
- R5: The first serial-clock transition comes exactly `cs_wait`+`clk_div`+1 cycles after the select line falls. The select line rises exactly `clk_div`+1 cycles after the last transition.
- R6: With `cpha`=0, MISO is sampled on the leading (first) edge of each clock period and MOSI changes only on trailing edges. The first bit is on MOSI from the moment the select line falls.
- R7: With `cpha`=1, MOSI changes on the leading edge and MISO is sampled on the trailing edge.
- R8: Bits leave MSB first from bit `word_len`-1 of the word. Each received bit enters at the LSB. After the last sample of each word, `rx_data` shows the received word right-aligned with zero upper bits, and `rx_valid` is high for exactly one cycle.
- R9: `word_len` sets the bits per word from 8 to 16 with 2×length clock edges per word. Values below 8 act as 8 and values above 16 act as 16.
- R10: A word pushed while busy is sent directly after the current word under the same select. When no word is pending at the end of a word, the transaction ends and every pushed word has produced one `rx_valid`.
- R11: A start strobe while `busy` is 1 changes nothing: selection, mode and data stay those of the running transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transaction (idle only) |
| cpol | input | 1 | Clock idle level for the new transaction |
| cpha | input | 1 | Clock phase for the new transaction |
| word_len | input | 5 | Bits per word, clamped to 8..16 |
| clk_div | input | 8 | Half period minus one, in system clocks |
| cs_wait | input | 8 | Extra cycles between select and first edge |
| cs_sel | input | 2 | Index of the peripheral to select |
| tx_data | input | 16 | First word, taken with `start` |
| push | input | 1 | Offer a further word while busy |
| push_data | input | 16 | Word offered with `push` |
| busy | output | 1 | Transaction in progress |
| rx_valid | output | 1 | One-cycle pulse: `rx_data` holds a new word |
| rx_data | output | 16 | Received word, right-aligned |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data towards the peripheral |
| miso | input | 1 | Serial data from the peripheral |
| cs_n | output | 4 | Active-low select lines |

## Verification
The bench keeps the default parameters: 16-bit maximum word, four select lines and 8-bit divider and wait fields. This lets a single build run all four modes and the lengths 8, 12 and 16. Out-of-range requests of 5 and 20 bits test the clamp. Divider values 0 to 3 and waits 0 to 5 exercise the exact edge spacing, including a one-cycle half period. A peripheral model in the bench launches and samples according to the mode, and a three-word transaction with a stray start tests the push slot and the busy guard.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_WAIT,
    ST_XFER,
    ST_TAIL
  } spim_state_t;
endpackage

// File: rtl/spim_halfper.sv
`timescale 1ns/1ps
module spim_halfper #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [DIVW-1:0] div,
  output logic            tick
);
  logic [DIVW-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt_q <= '0;
    else                     cnt_q <= cnt_q + DIVW'(1);
  end

  // R4: the counter never passes the half-period limit
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_q <= div));
endmodule

// File: rtl/spim_shift.sv
`timescale 1ns/1ps
module spim_shift #(
  parameter int MAXW = 16,
  parameter int LENW = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [MAXW-1:0] load_data,
  input  logic [LENW-1:0] len,
  input  logic            cpha,
  input  logic            lead,
  input  logic            trail,
  input  logic            last,
  input  logic            miso,
  output logic            mosi,
  output logic            rx_valid,
  output logic [MAXW-1:0] rx_data
);
  logic [MAXW-1:0] sh_q, rx_q, shifted;
  logic [MAXW-1:0] msb_sel, nxt_sel, keep;
  logic            samp_q, mosi_q, rxv_q, in_bit;

  for (genvar g = 0; g < MAXW; g++) begin : g_sel
    assign msb_sel[g] = (LENW'(g) == len - LENW'(1));
    assign nxt_sel[g] = (LENW'(g) == len - LENW'(2));
    assign keep[g]    = (LENW'(g) <  len);
  end

  assign in_bit  = cpha ? miso : samp_q;
  assign shifted = {sh_q[MAXW-2:0], in_bit};

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      rx_q   <= '0;
      samp_q <= 1'b0;
      mosi_q <= 1'b0;
      rxv_q  <= 1'b0;
    end else begin
      rxv_q <= 1'b0;
      if (lead && !cpha) samp_q <= miso;
      if (lead && cpha)  mosi_q <= |(sh_q & msb_sel);
      if (trail) begin
        sh_q <= shifted;
        if (!cpha) mosi_q <= |(sh_q & nxt_sel);
      end
      if (last) begin
        rxv_q <= 1'b1;
        rx_q  <= shifted & keep;
      end
      if (load) begin
        sh_q <= load_data;
        if (!cpha || !trail) mosi_q <= |(load_data & msb_sel);
      end
    end
  end

  assign mosi     = mosi_q;
  assign rx_valid = rxv_q;
  assign rx_data  = rx_q;

  // R8: the valid strobe lasts a single cycle
  p_rx_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    rxv_q |=> !rxv_q);
  // R6: with phase 0, MOSI does not move on a leading edge
  p_lead_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (lead && !cpha && !load) |=> $stable(mosi_q));
endmodule

// File: rtl/spi_mode_master.sv
`timescale 1ns/1ps
module spi_mode_master
  import spim_pkg::*;
#(
  parameter int MAXW  = 16,
  parameter int MINW  = 8,
  parameter int NCS   = 4,
  parameter int DIVW  = 8,
  parameter int WAITW = 8,
  parameter int LENW  = $clog2(MAXW + 1),
  parameter int IDXW  = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             cpol,
  input  logic             cpha,
  input  logic [LENW-1:0]  word_len,
  input  logic [DIVW-1:0]  clk_div,
  input  logic [WAITW-1:0] cs_wait,
  input  logic [IDXW-1:0]  cs_sel,
  input  logic [MAXW-1:0]  tx_data,
  input  logic             push,
  input  logic [MAXW-1:0]  push_data,
  output logic             busy,
  output logic             rx_valid,
  output logic [MAXW-1:0]  rx_data,
  output logic             sck,
  output logic             mosi,
  input  logic             miso,
  output logic [NCS-1:0]   cs_n
);
  localparam int ECW = LENW + 1;

  spim_state_t      state_q;
  logic             cpol_q, cpha_q, sck_q, pend_v_q;
  logic [LENW-1:0]  wl_q, len_in, sh_len;
  logic [DIVW-1:0]  div_q;
  logic [WAITW-1:0] wait_q, wcnt_q;
  logic [ECW-1:0]   ecnt_q, last_idx;
  logic [IDXW-1:0]  sel_q;
  logic [NCS-1:0]   cs_n_q, sel_vec;
  logic [MAXW-1:0]  pend_d_q;
  logic             tick, run, edge_go, lead, trail, last_edge, reload;
  logic             take_start, load, sh_cpha, slot_open;

  always_comb begin
    if (word_len < LENW'(MINW))      len_in = LENW'(MINW);
    else if (word_len > LENW'(MAXW)) len_in = LENW'(MAXW);
    else                             len_in = word_len;
  end

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    assign sel_vec[g] = (sel_q != IDXW'(g));
  end

  assign run        = (state_q == ST_XFER) || (state_q == ST_TAIL);
  assign edge_go    = (state_q == ST_XFER) && tick;
  assign lead       = edge_go && !ecnt_q[0];
  assign trail      = edge_go &&  ecnt_q[0];
  assign last_idx   = {wl_q, 1'b0} - ECW'(1);
  assign last_edge  = trail && (ecnt_q == last_idx);
  assign reload     = last_edge && pend_v_q;
  assign take_start = (state_q == ST_IDLE) && start;
  assign load       = take_start || reload;
  assign sh_len     = (state_q == ST_IDLE) ? len_in : wl_q;
  assign sh_cpha    = (state_q == ST_IDLE) ? cpha : cpha_q;
  assign slot_open  = (state_q == ST_ARM) || (state_q == ST_WAIT) || (state_q == ST_XFER);

  spim_halfper #(.DIVW(DIVW)) u_timer (
    .clk (clk),
    .rst (rst),
    .run (run),
    .div (div_q),
    .tick(tick)
  );

  spim_shift #(.MAXW(MAXW), .LENW(LENW)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_data(reload ? pend_d_q : tx_data),
    .len      (sh_len),
    .cpha     (sh_cpha),
    .lead     (lead),
    .trail    (trail),
    .last     (last_edge),
    .miso     (miso),
    .mosi     (mosi),
    .rx_valid (rx_valid),
    .rx_data  (rx_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cpol_q   <= 1'b0;
      cpha_q   <= 1'b0;
      sck_q    <= 1'b0;
      wl_q     <= LENW'(MINW);
      div_q    <= '0;
      wait_q   <= '0;
      wcnt_q   <= '0;
      ecnt_q   <= '0;
      sel_q    <= '0;
      cs_n_q   <= '1;
      pend_v_q <= 1'b0;
      pend_d_q <= '0;
    end else begin
      if (reload) pend_v_q <= 1'b0;
      if (push && slot_open && (!pend_v_q || reload)) begin
        pend_v_q <= 1'b1;
        pend_d_q <= push_data;
      end
      unique case (state_q)
        ST_IDLE: if (start) begin
          cpol_q   <= cpol;
          cpha_q   <= cpha;
          wl_q     <= len_in;
          div_q    <= clk_div;
          wait_q   <= cs_wait;
          sel_q    <= cs_sel;
          sck_q    <= cpol;
          ecnt_q   <= '0;
          pend_v_q <= 1'b0;
          state_q  <= ST_ARM;
        end
        ST_ARM: begin
          cs_n_q  <= sel_vec;
          wcnt_q  <= WAITW'(1);
          state_q <= (wait_q == '0) ? ST_XFER : ST_WAIT;
        end
        ST_WAIT: begin
          if (wcnt_q == wait_q) state_q <= ST_XFER;
          else                  wcnt_q  <= wcnt_q + WAITW'(1);
        end
        ST_XFER: if (tick) begin
          sck_q <= ~sck_q;
          if (last_edge) begin
            ecnt_q <= '0;
            if (!pend_v_q) state_q <= ST_TAIL;
          end else begin
            ecnt_q <= ecnt_q + ECW'(1);
          end
        end
        ST_TAIL: if (tick) begin
          cs_n_q   <= '1;
          pend_v_q <= 1'b0;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign sck  = sck_q;
  assign cs_n = cs_n_q;

  // R2: never more than one select line low
  p_cs_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n_q));
  // R3: clock parked at idle level around select changes
  p_sck_idle_r3: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_ARM) || (state_q == ST_TAIL)) |-> (sck_q == cpol_q));
  // R4: clock moves only while shifting (or when parked at start)
  p_sck_moves_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(sck_q) |-> ($past(state_q) == ST_XFER || $past(state_q) == ST_IDLE));
  // R10: select released only from the tail phase
  p_cs_release_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(&cs_n_q) |-> ($past(state_q) == ST_TAIL));
  // R11: a start while busy leaves the latched setup alone
  p_start_busy_r11: assert property (@(posedge clk) disable iff (rst)
    (start && busy) |=> ($stable(sel_q) && $stable(cpol_q) && $stable(wl_q)));
endmodule

// File: tb/spi_mode_master_tb.sv
`timescale 1ns/1ps
module spi_mode_master_tb;
  logic        clk = 1'b0, rst = 1'b1;
  logic        start = 0, cpol = 0, cpha = 0, push = 0, miso = 0;
  logic [4:0]  word_len = 5'd8;
  logic [7:0]  clk_div = 0, cs_wait = 0;
  logic [1:0]  cs_sel = 0;
  logic [15:0] tx_data = 0, push_data = 0;
  logic        busy, rx_valid, sck, mosi;
  logic [15:0] rx_data;
  logic [3:0]  cs_n;

  always #2 clk = ~clk;

  spi_mode_master u_dut (
    .clk(clk), .rst(rst), .start(start), .cpol(cpol), .cpha(cpha),
    .word_len(word_len), .clk_div(clk_div), .cs_wait(cs_wait), .cs_sel(cs_sel),
    .tx_data(tx_data), .push(push), .push_data(push_data), .busy(busy),
    .rx_valid(rx_valid), .rx_data(rx_data), .sck(sck), .mosi(mosi),
    .miso(miso), .cs_n(cs_n)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // configuration of the running transaction, as the peripheral model sees it
  int c_cpol, c_cpha, c_wl, c_div, c_wait, c_idx, c_n;
  logic [15:0] tx_w [4];
  logic [15:0] rs_w [4];
  logic [15:0] exp_q [$];

  // scoreboard monitor
  always @(negedge clk) if (!rst && rx_valid) begin
    if (exp_q.size() == 0) chk(0, "R8 unexpected word", rx_data, 0);
    else begin
      logic [15:0] e;
      e = exp_q.pop_front();
      chk(rx_data == e, "R8 received word", rx_data, e);
    end
  end

  // peripheral model
  bit s_act = 0, s_prev_sck = 0, s_first = 0;
  int s_edges = 0, s_word = 0, s_mark = 0, s_tot = 0;
  logic [15:0] s_rx = 0;
  logic [3:0]  s_cs = 4'hF;
  always @(negedge clk) if (!rst) begin
    bit active;
    active = (cs_n != 4'hF);
    if (active && !s_act) begin
      chk(cs_n == ~(4'b1 << c_idx), "R2 select pattern", cs_n, ~(4'b1 << c_idx));
      chk(sck == c_cpol[0] && s_prev_sck == c_cpol[0], "R3 idle before select", sck, c_cpol);
      s_cs = cs_n; s_edges = 0; s_word = 0; s_rx = 0; s_mark = cyc; s_first = 1; s_tot = 0;
      miso = rs_w[0][c_wl-1];
    end else if (active && s_act) begin
      if (cs_n != s_cs) chk(0, "R2 select held", cs_n, s_cs);
      if (sck != s_prev_sck) begin
        bit lead, samp;
        int gap, eg;
        gap = cyc - s_mark;
        eg  = s_first ? c_wait + c_div + 1 : c_div + 1;
        if (s_first) chk(gap == eg, "R5 first edge delay", gap, eg);
        else if (gap != eg) chk(0, "R4 half period", gap, eg);
        s_first = 0; s_mark = cyc;
        lead = (sck != c_cpol[0]);
        samp = c_cpha[0] ? !lead : lead;
        if (samp) s_rx = {s_rx[14:0], mosi};
        s_edges++; s_tot++;
        if (!samp) begin
          int b;
          b = c_cpha[0] ? (s_edges - 1) / 2 : s_edges / 2;
          if (b < c_wl) miso = rs_w[s_word][c_wl-1-b];
        end
        if (s_edges == 2 * c_wl) begin
          logic [15:0] e;
          e = tx_w[s_word] & 16'((32'h1 << c_wl) - 1);
          chk(s_rx == e, c_cpha[0] ? "R7 MOSI word" : "R6 MOSI word", s_rx, e);
          if (!c_cpha[0] && s_word + 1 < c_n) miso = rs_w[s_word+1][c_wl-1];
          s_word++; s_edges = 0; s_rx = 0;
        end
      end
    end else if (!active && s_act) begin
      chk(cyc - s_mark == c_div + 1, "R5 select release delay", cyc - s_mark, c_div + 1);
      chk(sck == c_cpol[0], "R3 idle after transaction", sck, c_cpol);
      chk(s_word == c_n, "R10 words under one select", s_word, c_n);
    end
    s_act = active;
    s_prev_sck = sck;
  end

  task automatic run_txn(input int t, input int cp, input int ch, input int wl, input int dv,
                         input int wt, input int ix, input int n, input bit stray);
    c_cpol = cp; c_cpha = ch; c_div = dv; c_wait = wt; c_idx = ix; c_n = n;
    c_wl = (wl < 8) ? 8 : (wl > 16) ? 16 : wl;
    for (int i = 0; i < n; i++) begin
      tx_w[i] = 16'(32'hA5C3 ^ (t * 32'h1357) ^ (i * 32'h2468));
      rs_w[i] = 16'(32'h3C96 + t * 32'h0F1E + i * 32'h7B2D);
      exp_q.push_back(rs_w[i] & 16'((32'h1 << c_wl) - 1));
    end
    @(negedge clk);
    start = 1; cpol = cp[0]; cpha = ch[0]; word_len = 5'(wl); clk_div = 8'(dv);
    cs_wait = 8'(wt); cs_sel = 2'(ix); tx_data = tx_w[0];
    @(negedge clk);
    start = 0;
    if (n > 1) begin
      push = 1; push_data = tx_w[1];
      @(negedge clk);
      push = 0;
    end
    if (stray) begin
      start = 1; cs_sel = 2'(ix + 2); cpol = ~cp[0]; word_len = 5'd16; tx_data = 16'hFFFF;
      @(negedge clk);
      start = 0;
      chk(busy && cs_n == ~(4'b1 << ix), "R11 start while busy", cs_n, ~(4'b1 << ix));
    end
    for (int k = 2; k < n; k++) begin
      do @(negedge clk); while (!rx_valid);
      push = 1; push_data = tx_w[k];
      @(negedge clk);
      push = 0;
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, "R10 all words reported", exp_q.size(), 0);
    chk(s_tot == 2 * c_wl * n, "R9 edges per transaction", s_tot, 2 * c_wl * n);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R10 actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(cs_n == 4'hF, "R1 select idle", cs_n, 4'hF);
    chk(sck == 0 && mosi == 0, "R1 serial outputs", {sck, mosi}, 0);
    chk(busy == 0 && rx_valid == 0, "R1 status", {busy, rx_valid}, 0);
    run_txn(0, 0, 0,  8, 1, 0, 0, 1, 0);
    run_txn(1, 0, 1, 12, 2, 3, 1, 3, 1);
    run_txn(2, 1, 0, 16, 0, 1, 2, 2, 0);
    run_txn(3, 1, 1,  8, 3, 5, 3, 2, 0);
    run_txn(4, 0, 0,  5, 0, 0, 1, 1, 0);
    run_txn(5, 1, 1, 20, 1, 2, 0, 1, 0);
    run_txn(6, 0, 1, 16, 0, 0, 3, 2, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule